// File: doc/BRIEF.md
# Interleaved Two-Region Banked Memory Arbiter

This block sits in front of a processing element's private SRAM. The SRAM is built from 64-bit-wide banks and occupies part of a 21-bit byte address space. Two data ports and one instruction-fetch port may each present a request in every cycle. The block decodes each address into a region, a bank and a word. It refuses accesses that are unaligned, unpopulated or not allowed, and it grants every request whose banks are free. Accesses that land on the same bank are served one after another.

The lower region (0x4C000 to 0x7FFFF) maps each aligned 64 KB block of addresses onto one bank. The upper region (0x80000 to 0xE7FFF) is built from bank pairs that each cover 128 KB. Inside a pair, address bit 3 picks the even or the odd bank, so consecutive 64-bit words alternate between the two. A 16-byte access in the upper region therefore uses both banks of a pair in one grant. Fetches are served only from the lower region.

Each bank is modelled as a small array of 2^DEPTH_LOG2 words. Within a bank, words alias on the low bits of their word index. A grant is given combinationally in the request cycle. The acknowledge, the error flag and the read data follow one cycle later. A requester that is not granted keeps its request up and tries again.

Top module: `tile_bank_arbiter`

## Requirements
- R1: Only byte addresses 0x4C000 through 0xE7FFF are populated. An access whose address falls outside that window is granted and acknowledged with the error flag set, and it touches no bank.
- R2: Every data access is naturally aligned to its size, and a fetch is aligned to 8 bytes. An unaligned access is flagged as an error and leaves memory unchanged.
- R3: The size code is 0 for 1 byte, 1 for 2, 2 for 4, 3 for 8 and 4 for 16 bytes. Codes 5 to 7 and a 16-byte access below 0x80000 are errors. A narrower read returns the addressed bytes zero-extended in the low bits of the read data, and a narrower write changes only the addressed bytes.
- R4: Below 0x80000, address bits 19:16 select the bank, so two addresses in different 64 KB blocks hold independent data.
- R5: From 0x80000 upward, address bit 3 selects the even or the odd bank of a pair. A 16-byte access returns the word at its address in bits 63:0 and the next word in bits 127:64, using a single grant.
- R6: Requests whose banks do not overlap are all granted in the same cycle.
- R7: When requests overlap on a bank, data port 0 is granted, data port 1 yields to port 0, and fetch yields to both. A refused port sees its grant and acknowledge low and no access is made for it.
- R8: A fetch reads 8 bytes from the lower region only. A fetch at or above 0x80000 is flagged as an error.
- R9: An acknowledge follows each grant exactly one cycle later, with the read data and the error flag valid in that cycle. An erroneous or write access returns read data of zero.
- R10: After reset no acknowledge or error is raised until a request is granted, and data port 0 is granted in every cycle it requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| d0_req | input | 1 | Data port 0 request |
| d0_we | input | 1 | Data port 0 write enable |
| d0_size | input | 3 | Data port 0 size code |
| d0_addr | input | 21 | Data port 0 byte address |
| d0_wdata | input | 128 | Data port 0 write data, low bytes used for narrow writes |
| d0_gnt | output | 1 | Data port 0 grant, same cycle |
| d0_ack | output | 1 | Data port 0 acknowledge, one cycle after grant |
| d0_err | output | 1 | Data port 0 access refused |
| d0_rdata | output | 128 | Data port 0 read data |
| d1_req | input | 1 | Data port 1 request |
| d1_we | input | 1 | Data port 1 write enable |
| d1_size | input | 3 | Data port 1 size code |
| d1_addr | input | 21 | Data port 1 byte address |
| d1_wdata | input | 128 | Data port 1 write data |
| d1_gnt | output | 1 | Data port 1 grant |
| d1_ack | output | 1 | Data port 1 acknowledge |
| d1_err | output | 1 | Data port 1 access refused |
| d1_rdata | output | 128 | Data port 1 read data |
| if_req | input | 1 | Fetch request |
| if_addr | input | 21 | Fetch byte address |
| if_gnt | output | 1 | Fetch grant |
| if_ack | output | 1 | Fetch acknowledge |
| if_err | output | 1 | Fetch refused |
| if_rdata | output | 64 | Fetch data |

## Verification
Bank arbitration and the interleaved wide access can happen in the same cycle. A 16-byte read on port 0 takes both banks of a pair, while port 1 or the fetch port may be aimed at one of those banks or at a different bank. The bench provokes this with directed pairs of requests: two words an odd number apart (both granted), two words an even number apart in the upper region (port 1 refused), and a fetch aimed at a bank that port 0 holds. It judges each case by the grants in the request cycle and by the data and acknowledges one cycle later. It also checks that an erroneous request on one port never blocks the other port.

// File: rtl/tba_pkg.sv
// Shared size codes and lane helpers for the banked memory arbiter.
// Assumes a 64-bit bank word split into eight byte lanes.
package tba_pkg;

    localparam int WORD_W = 64;

    typedef enum logic [2:0] {
        SZ_BYTE  = 3'd0,
        SZ_HALF  = 3'd1,
        SZ_WORD  = 3'd2,
        SZ_DWORD = 3'd3,
        SZ_QUAD  = 3'd4
    } acc_size_e;

    // Byte-lane mask of an access of the given size starting at lane 0.
    function automatic logic [7:0] size_lanes(input logic [2:0] sz);
        case (sz)
            SZ_BYTE: return 8'h01;
            SZ_HALF: return 8'h03;
            SZ_WORD: return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    // Moves narrow write data up to its byte lane.
    function automatic logic [WORD_W-1:0] to_lane(input logic [WORD_W-1:0] d,
                                                  input logic [2:0] lane);
        return d << {lane, 3'b000};
    endfunction

endpackage

// File: rtl/tba_decode.sv
// Address decoder for one requester. Classifies the access as legal or
// faulty and maps it onto a bank, a second bank for 16-byte accesses,
// a word index and a byte lane. Assumes bank blocks are aligned to
// 2^BANK_LOG2 bytes and that the upper region starts on a pair boundary.
module tba_decode
    import tba_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int POP_LO     = 'h4C000,
    parameter int POP_HI     = 'hE7FFF,
    parameter int R1_BASE    = 'h80000,
    parameter int BANK_LOG2  = 16,
    parameter int DEPTH_LOG2 = 4,
    parameter int R0_FIRST   = 4,
    parameter int R0_BANKS   = 4,
    parameter int NB         = 12,
    parameter int BW         = 4,
    parameter bit FETCH_ONLY = 1'b0
) (
    input  logic                  req,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2:0]            size,
    output logic                  legal,
    output logic                  fault,
    output logic [NB-1:0]         mask,
    output logic [BW-1:0]         bank_lo,
    output logic [BW-1:0]         bank_hi,
    output logic                  wide,
    output logic [DEPTH_LOG2-1:0] idx,
    output logic [2:0]            lane
);

    localparam logic [ADDR_W-1:0] LO_A = POP_LO[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] HI_A = POP_HI[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] R1_A = R1_BASE[ADDR_W-1:0];
    localparam int                PAIR_LOG2 = BANK_LOG2 + 1;

    logic in_pop, in_r1, misal, bad_size, bad;
    logic [BW-1:0] bank_r0, bank_r1;

    // Classifies the access against the map, alignment and size rules.
    always_comb begin
        in_pop = (addr >= LO_A) && (addr <= HI_A);
        in_r1  = (addr >= R1_A);
        case (size)
            SZ_BYTE:  misal = 1'b0;
            SZ_HALF:  misal = addr[0];
            SZ_WORD:  misal = |addr[1:0];
            SZ_DWORD: misal = |addr[2:0];
            SZ_QUAD:  misal = |addr[3:0];
            default:  misal = 1'b0;
        endcase
        bad_size = (size > SZ_QUAD) || ((size == SZ_QUAD) && !in_r1);
        if (FETCH_ONLY) begin
            bad_size = (size != SZ_DWORD) || in_r1;
        end
        bad   = !in_pop || misal || bad_size;
        legal = req && !bad;
        fault = req && bad;
    end

    // Maps the address onto bank numbers and the in-bank word index.
    always_comb begin
        bank_r0 = BW'(addr >> BANK_LOG2) - BW'(R0_FIRST);
        bank_r1 = BW'(R0_BANKS) + (BW'((addr - R1_A) >> PAIR_LOG2) << 1)
                  + BW'(addr[3]);
        bank_lo = in_r1 ? bank_r1 : bank_r0;
        bank_hi = bank_lo + BW'(1);
        idx     = in_r1 ? addr[4 +: DEPTH_LOG2] : addr[3 +: DEPTH_LOG2];
        wide    = (size == SZ_QUAD);
        lane    = addr[2:0];
        mask    = '0;
        if (legal) begin
            mask = NB'(1) << bank_lo;
            if (wide) begin
                mask = mask | (NB'(1) << bank_hi);
            end
        end
    end

endmodule

// File: rtl/tba_arbiter.sv
// Fixed-priority bank arbiter. Port 0 always wins, port 1 yields to the
// banks port 0 takes, fetch yields to both. Faulty requests carry an empty
// bank mask, so they are always granted and never block anyone.
module tba_arbiter #(
    parameter int NB = 12
) (
    input  logic          req0,
    input  logic          req1,
    input  logic          reqf,
    input  logic [NB-1:0] m0,
    input  logic [NB-1:0] m1,
    input  logic [NB-1:0] mf,
    output logic          gnt0,
    output logic          gnt1,
    output logic          gntf,
    output logic [NB-1:0] own0,
    output logic [NB-1:0] own1,
    output logic [NB-1:0] ownf
);

    // Grants each port in priority order against the banks already taken.
    always_comb begin
        gnt0 = req0;
        own0 = gnt0 ? m0 : '0;
        gnt1 = req1 && ((m1 & own0) == '0);
        own1 = gnt1 ? m1 : '0;
        gntf = reqf && ((mf & (own0 | own1)) == '0);
        ownf = gntf ? mf : '0;
    end

endmodule

// File: rtl/tba_bank.sv
// One 64-bit bank with byte write enables and a registered read port.
// Assumes at most one access per cycle; storage itself is not reset.
module tba_bank #(
    parameter int DEPTH_LOG2 = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  we,
    input  logic [DEPTH_LOG2-1:0] idx,
    input  logic [63:0]           wdata,
    input  logic [7:0]            be,
    output logic [63:0]           rdata
);

    localparam int DEPTH = 1 << DEPTH_LOG2;

    logic [63:0] store [DEPTH];

    // Writes the enabled byte lanes of the addressed word.
    always_ff @(posedge clk) begin
        if (en && we) begin
            for (int i = 0; i < 8; i++) begin
                if (be[i]) begin
                    store[idx][8*i +: 8] <= wdata[8*i +: 8];
                end
            end
        end
    end

    // Captures the addressed word on a read; holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (en && !we) begin
            rdata <= store[idx];
        end
    end

endmodule

// File: rtl/tba_resp.sv
// Response stage of one requester: registers the grant, the fault and the
// bank selection, then steers and trims the bank read data one cycle later.
// RD_W of 64 serves the fetch port, which never issues 16-byte accesses.
module tba_resp
    import tba_pkg::*;
#(
    parameter int NB   = 12,
    parameter int BW   = 4,
    parameter int RD_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gnt,
    input  logic             fault,
    input  logic             rd,
    input  logic [BW-1:0]    bank_lo,
    input  logic [BW-1:0]    bank_hi,
    input  logic             wide,
    input  logic [2:0]       lane,
    input  logic [2:0]       size,
    input  logic [NB*64-1:0] bank_rd,
    output logic             ack,
    output logic             err,
    output logic [RD_W-1:0]  rdata
);

    logic          rd_q, wide_q;
    logic [BW-1:0] lo_q, hi_q;
    logic [2:0]    lane_q, size_q;
    logic [63:0]   word_lo, word_hi, shifted, narrow;

    // Records what the granted access needs for its answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack    <= 1'b0;
            err    <= 1'b0;
            rd_q   <= 1'b0;
            wide_q <= 1'b0;
            lo_q   <= '0;
            hi_q   <= '0;
            lane_q <= '0;
            size_q <= '0;
        end else begin
            ack    <= gnt;
            err    <= gnt && fault;
            rd_q   <= gnt && rd;
            wide_q <= wide;
            lo_q   <= bank_lo;
            hi_q   <= bank_hi;
            lane_q <= lane;
            size_q <= size;
        end
    end

    // Picks the bank words and extracts a narrow field from its lane.
    always_comb begin
        word_lo = bank_rd[int'(lo_q)*64 +: 64];
        word_hi = bank_rd[int'(hi_q)*64 +: 64];
        shifted = word_lo >> {lane_q, 3'b000};
        case (size_q)
            SZ_BYTE: narrow = 64'(shifted[7:0]);
            SZ_HALF: narrow = 64'(shifted[15:0]);
            SZ_WORD: narrow = 64'(shifted[31:0]);
            default: narrow = shifted;
        endcase
    end

    generate
        if (RD_W > 64) begin : g_wide
            assign rdata = !rd_q ? '0 :
                           (wide_q ? {word_hi, word_lo} : RD_W'(narrow));
        end else begin : g_narrow
            assign rdata = !rd_q ? '0 : (wide_q ? word_hi : narrow);
        end
    endgenerate

endmodule

// File: rtl/tile_bank_arbiter.sv
// Front end of a banked local SRAM: two data ports and one fetch port,
// a lower linearly banked region and an upper region of interleaved bank
// pairs. Grants are combinational, answers arrive one cycle later.
// Assumes requesters hold a refused request until it is granted.
module tile_bank_arbiter
    import tba_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int POP_LO     = 'h4C000,
    parameter int POP_HI     = 'hE7FFF,
    parameter int R1_BASE    = 'h80000,
    parameter int BANK_LOG2  = 16,
    parameter int DEPTH_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d0_req,
    input  logic              d0_we,
    input  logic [2:0]        d0_size,
    input  logic [ADDR_W-1:0] d0_addr,
    input  logic [127:0]      d0_wdata,
    output logic              d0_gnt,
    output logic              d0_ack,
    output logic              d0_err,
    output logic [127:0]      d0_rdata,
    input  logic              d1_req,
    input  logic              d1_we,
    input  logic [2:0]        d1_size,
    input  logic [ADDR_W-1:0] d1_addr,
    input  logic [127:0]      d1_wdata,
    output logic              d1_gnt,
    output logic              d1_ack,
    output logic              d1_err,
    output logic [127:0]      d1_rdata,
    input  logic              if_req,
    input  logic [ADDR_W-1:0] if_addr,
    output logic              if_gnt,
    output logic              if_ack,
    output logic              if_err,
    output logic [63:0]       if_rdata
);

    localparam int PAIR_LOG2 = BANK_LOG2 + 1;
    localparam int R0_FIRST  = POP_LO >> BANK_LOG2;
    localparam int R0_BANKS  = (R1_BASE >> BANK_LOG2) - R0_FIRST;
    localparam int R1_PAIRS  = (POP_HI + 1 - R1_BASE + (1 << PAIR_LOG2) - 1)
                               >> PAIR_LOG2;
    localparam int NB        = R0_BANKS + 2 * R1_PAIRS;
    localparam int BW        = $clog2(NB);

    logic                  legal0, legal1, legalf;
    logic                  fault0, fault1, faultf;
    logic [NB-1:0]         m0, m1, mf, own0, own1, ownf;
    logic [BW-1:0]         blo0, blo1, blof, bhi0, bhi1, bhif;
    logic                  wide0, wide1, widef;
    logic [DEPTH_LOG2-1:0] idx0, idx1, idxf;
    logic [2:0]            lane0, lane1, lanef;
    logic [63:0]           wlo0, wlo1;
    logic [7:0]            belo0, belo1;
    logic [NB*64-1:0]      bank_rd;
    logic [63:0]           f_rdata;

    tba_decode #(
        .ADDR_W(ADDR_W), .POP_LO(POP_LO), .POP_HI(POP_HI), .R1_BASE(R1_BASE),
        .BANK_LOG2(BANK_LOG2), .DEPTH_LOG2(DEPTH_LOG2), .R0_FIRST(R0_FIRST),
        .R0_BANKS(R0_BANKS), .NB(NB), .BW(BW), .FETCH_ONLY(1'b0)
    ) u_dec0 (
        .req(d0_req), .addr(d0_addr), .size(d0_size), .legal(legal0),
        .fault(fault0), .mask(m0), .bank_lo(blo0), .bank_hi(bhi0),
        .wide(wide0), .idx(idx0), .lane(lane0)
    );

    tba_decode #(
        .ADDR_W(ADDR_W), .POP_LO(POP_LO), .POP_HI(POP_HI), .R1_BASE(R1_BASE),
        .BANK_LOG2(BANK_LOG2), .DEPTH_LOG2(DEPTH_LOG2), .R0_FIRST(R0_FIRST),
        .R0_BANKS(R0_BANKS), .NB(NB), .BW(BW), .FETCH_ONLY(1'b0)
    ) u_dec1 (
        .req(d1_req), .addr(d1_addr), .size(d1_size), .legal(legal1),
        .fault(fault1), .mask(m1), .bank_lo(blo1), .bank_hi(bhi1),
        .wide(wide1), .idx(idx1), .lane(lane1)
    );

    tba_decode #(
        .ADDR_W(ADDR_W), .POP_LO(POP_LO), .POP_HI(POP_HI), .R1_BASE(R1_BASE),
        .BANK_LOG2(BANK_LOG2), .DEPTH_LOG2(DEPTH_LOG2), .R0_FIRST(R0_FIRST),
        .R0_BANKS(R0_BANKS), .NB(NB), .BW(BW), .FETCH_ONLY(1'b1)
    ) u_decf (
        .req(if_req), .addr(if_addr), .size(SZ_DWORD), .legal(legalf),
        .fault(faultf), .mask(mf), .bank_lo(blof), .bank_hi(bhif),
        .wide(widef), .idx(idxf), .lane(lanef)
    );

    tba_arbiter #(.NB(NB)) u_arb (
        .req0(d0_req), .req1(d1_req), .reqf(if_req),
        .m0(m0), .m1(m1), .mf(mf),
        .gnt0(d0_gnt), .gnt1(d1_gnt), .gntf(if_gnt),
        .own0(own0), .own1(own1), .ownf(ownf)
    );

    // Places narrow write data and byte enables on their lanes.
    always_comb begin
        wlo0  = to_lane(d0_wdata[63:0], lane0);
        wlo1  = to_lane(d1_wdata[63:0], lane1);
        belo0 = wide0 ? 8'hFF : (size_lanes(d0_size) << lane0);
        belo1 = wide1 ? 8'hFF : (size_lanes(d1_size) << lane1);
    end

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bank
            logic                  b_en, b_we;
            logic [DEPTH_LOG2-1:0] b_idx;
            logic [63:0]           b_wd;
            logic [7:0]            b_be;

            // Routes the single owner of this bank onto its access port.
            always_comb begin
                b_en  = 1'b0;
                b_we  = 1'b0;
                b_idx = '0;
                b_wd  = '0;
                b_be  = '0;
                if (own0[b]) begin
                    b_en  = 1'b1;
                    b_we  = d0_we;
                    b_idx = idx0;
                    if (wide0 && (bhi0 == BW'(b))) begin
                        b_wd = d0_wdata[127:64];
                        b_be = 8'hFF;
                    end else begin
                        b_wd = wlo0;
                        b_be = belo0;
                    end
                end else if (own1[b]) begin
                    b_en  = 1'b1;
                    b_we  = d1_we;
                    b_idx = idx1;
                    if (wide1 && (bhi1 == BW'(b))) begin
                        b_wd = d1_wdata[127:64];
                        b_be = 8'hFF;
                    end else begin
                        b_wd = wlo1;
                        b_be = belo1;
                    end
                end else if (ownf[b]) begin
                    b_en  = 1'b1;
                    b_idx = idxf;
                end
            end

            tba_bank #(.DEPTH_LOG2(DEPTH_LOG2)) u_bank (
                .clk(clk), .rst_n(rst_n), .en(b_en), .we(b_we), .idx(b_idx),
                .wdata(b_wd), .be(b_be), .rdata(bank_rd[b*64 +: 64])
            );
        end
    endgenerate

    tba_resp #(.NB(NB), .BW(BW), .RD_W(128)) u_resp0 (
        .clk(clk), .rst_n(rst_n), .gnt(d0_gnt), .fault(fault0),
        .rd(legal0 && !d0_we), .bank_lo(blo0), .bank_hi(bhi0), .wide(wide0),
        .lane(lane0), .size(d0_size), .bank_rd(bank_rd),
        .ack(d0_ack), .err(d0_err), .rdata(d0_rdata)
    );

    tba_resp #(.NB(NB), .BW(BW), .RD_W(128)) u_resp1 (
        .clk(clk), .rst_n(rst_n), .gnt(d1_gnt), .fault(fault1),
        .rd(legal1 && !d1_we), .bank_lo(blo1), .bank_hi(bhi1), .wide(wide1),
        .lane(lane1), .size(d1_size), .bank_rd(bank_rd),
        .ack(d1_ack), .err(d1_err), .rdata(d1_rdata)
    );

    tba_resp #(.NB(NB), .BW(BW), .RD_W(64)) u_respf (
        .clk(clk), .rst_n(rst_n), .gnt(if_gnt), .fault(faultf),
        .rd(legalf), .bank_lo(blof), .bank_hi(bhif), .wide(widef),
        .lane(lanef), .size(SZ_DWORD), .bank_rd(bank_rd),
        .ack(if_ack), .err(if_err), .rdata(f_rdata)
    );

    assign if_rdata = f_rdata;

endmodule

// File: rtl/tba_checker.sv
// Protocol and arbitration properties of tile_bank_arbiter, bound to it.
module tba_checker #(
    parameter int ADDR_W  = 21,
    parameter int POP_LO  = 'h4C000,
    parameter int R1_BASE = 'h80000,
    parameter int NB      = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              d0_req,
    input logic              d0_we,
    input logic [2:0]        d0_size,
    input logic [ADDR_W-1:0] d0_addr,
    input logic              d0_gnt,
    input logic              d0_ack,
    input logic              d0_err,
    input logic [127:0]      d0_rdata,
    input logic              d1_req,
    input logic [2:0]        d1_size,
    input logic [ADDR_W-1:0] d1_addr,
    input logic              d1_gnt,
    input logic              d1_ack,
    input logic              if_req,
    input logic [ADDR_W-1:0] if_addr,
    input logic              if_gnt,
    input logic              if_ack,
    input logic              if_err,
    input logic [NB-1:0]     own0,
    input logic [NB-1:0]     own1,
    input logic [NB-1:0]     ownf
);

    localparam logic [ADDR_W-1:0] LO_A = POP_LO[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] R1_A = R1_BASE[ADDR_W-1:0];

    a_r10_port0_granted: assert property (@(posedge clk) disable iff (!rst_n)
        d0_req |-> d0_gnt);

    a_r9_ack0_follows: assert property (@(posedge clk) disable iff (!rst_n)
        d0_gnt |=> d0_ack);

    a_r9_ack1_only_after_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        !d1_gnt |=> !d1_ack);

    a_r9_fetch_ack: assert property (@(posedge clk) disable iff (!rst_n)
        if_gnt |=> if_ack);

    a_r9_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        d0_err |-> (d0_ack && d0_rdata == '0));

    a_r2_unaligned_dword: assert property (@(posedge clk) disable iff (!rst_n)
        (d0_req && d0_size == 3'd3 && d0_addr[2:0] != 3'd0) |=> d0_err);

    a_r1_below_window: assert property (@(posedge clk) disable iff (!rst_n)
        (d0_req && d0_addr < LO_A) |=> d0_err);

    a_r8_fetch_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (if_req && if_gnt && if_addr >= R1_A) |=> if_err);

    a_r7_same_block_yields: assert property (@(posedge clk) disable iff (!rst_n)
        (d0_req && d1_req && !d0_we && d0_size == 3'd3 && d1_size == 3'd3 &&
         d0_addr[2:0] == 3'd0 && d1_addr[2:0] == 3'd0 &&
         d0_addr >= LO_A && d0_addr < R1_A && d1_addr >= LO_A && d1_addr < R1_A &&
         d0_addr[19:16] == d1_addr[19:16]) |-> !d1_gnt);

    generate
        for (genvar b = 0; b < NB; b++) begin : g_excl
            a_r7_bank_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0({own0[b], own1[b], ownf[b]}));
        end
    endgenerate

endmodule

bind tile_bank_arbiter tba_checker #(
    .ADDR_W(ADDR_W), .POP_LO(POP_LO), .R1_BASE(R1_BASE), .NB(NB)
) u_tba_checker (
    .clk(clk), .rst_n(rst_n), .d0_req(d0_req), .d0_we(d0_we),
    .d0_size(d0_size), .d0_addr(d0_addr), .d0_gnt(d0_gnt), .d0_ack(d0_ack),
    .d0_err(d0_err), .d0_rdata(d0_rdata), .d1_req(d1_req), .d1_size(d1_size),
    .d1_addr(d1_addr), .d1_gnt(d1_gnt), .d1_ack(d1_ack), .if_req(if_req),
    .if_addr(if_addr), .if_gnt(if_gnt), .if_ack(if_ack), .if_err(if_err),
    .own0(own0), .own1(own1), .ownf(ownf)
);

// File: tb/tile_bank_arbiter_bench.sv
`timescale 1ns/1ps
module tile_bank_arbiter_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         d0_req = 0, d0_we = 0, d1_req = 0, d1_we = 0, if_req = 0;
    logic [2:0]   d0_size = 0, d1_size = 0;
    logic [20:0]  d0_addr = 0, d1_addr = 0, if_addr = 0;
    logic [127:0] d0_wdata = 0, d1_wdata = 0;
    logic         d0_gnt, d0_ack, d0_err, d1_gnt, d1_ack, d1_err;
    logic         if_gnt, if_ack, if_err;
    logic [127:0] d0_rdata, d1_rdata;
    logic [63:0]  if_rdata;

    int total = 0;
    int bad   = 0;

    // Values captured by the cycle task.
    logic         g0, g1, gf, k0, k1, kf, e0, e1, ef;
    logic [127:0] r0, r1;
    logic [63:0]  rf;

    localparam logic [63:0] VA = 64'hA1A2_A3A4_A5A6_A7A8;
    localparam logic [63:0] VB = 64'hB1B2_B3B4_B5B6_B7B8;
    localparam logic [63:0] VC = 64'hC0C1_C2C3_C4C5_C6C7;
    localparam logic [63:0] VD = 64'hD0D1_D2D3_D4D5_D6D7;
    localparam logic [63:0] VG = 64'h6666_7777_8888_9999;
    localparam logic [63:0] VH = 64'h1357_9BDF_2468_ACE0;

    always #2 clk = ~clk;

    tile_bank_arbiter u_tile_bank_arbiter (
        .clk(clk), .rst_n(rst_n),
        .d0_req(d0_req), .d0_we(d0_we), .d0_size(d0_size), .d0_addr(d0_addr),
        .d0_wdata(d0_wdata), .d0_gnt(d0_gnt), .d0_ack(d0_ack), .d0_err(d0_err),
        .d0_rdata(d0_rdata),
        .d1_req(d1_req), .d1_we(d1_we), .d1_size(d1_size), .d1_addr(d1_addr),
        .d1_wdata(d1_wdata), .d1_gnt(d1_gnt), .d1_ack(d1_ack), .d1_err(d1_err),
        .d1_rdata(d1_rdata),
        .if_req(if_req), .if_addr(if_addr), .if_gnt(if_gnt), .if_ack(if_ack),
        .if_err(if_err), .if_rdata(if_rdata)
    );

    task automatic chk(input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Presents one request set, samples grants before the edge and answers
    // half a cycle after the following edge, then drops all requests.
    task automatic cyc(input logic q0, input logic w0, input logic [2:0] s0,
                       input logic [20:0] a0, input logic [127:0] wd0,
                       input logic q1, input logic w1, input logic [2:0] s1,
                       input logic [20:0] a1, input logic [127:0] wd1,
                       input logic qf, input logic [20:0] af);
        @(negedge clk);
        d0_req = q0; d0_we = w0; d0_size = s0; d0_addr = a0; d0_wdata = wd0;
        d1_req = q1; d1_we = w1; d1_size = s1; d1_addr = a1; d1_wdata = wd1;
        if_req = qf; if_addr = af;
        #1;
        g0 = d0_gnt; g1 = d1_gnt; gf = if_gnt;
        @(negedge clk);
        #1;
        k0 = d0_ack; k1 = d1_ack; kf = if_ack;
        e0 = d0_err; e1 = d1_err; ef = if_err;
        r0 = d0_rdata; r1 = d1_rdata; rf = if_rdata;
        d0_req = 0; d1_req = 0; if_req = 0;
    endtask

    // Port 0 alone.
    task automatic p0(input logic w, input logic [2:0] s, input logic [20:0] a,
                      input logic [127:0] wd);
        cyc(1, w, s, a, wd, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // R10: quiet outputs after reset.
    task automatic t_reset;
        @(negedge clk); #1;
        chk("R10 d0_ack after reset", d0_ack, 0);
        chk("R10 d1_ack after reset", d1_ack, 0);
        chk("R10 if_ack after reset", if_ack, 0);
        chk("R10 d0_err after reset", d0_err, 0);
        chk("R10 d0_rdata after reset", d0_rdata, 0);
    endtask

    // R4 R6 R9: independent lower-region banks served together.
    task automatic t_lower_banks;
        cyc(1, 1, 3, 21'h50000, 128'(VA), 1, 1, 3, 21'h60000, 128'(VB), 0, 0);
        chk("R6 both writes granted g0", g0, 1);
        chk("R6 both writes granted g1", g1, 1);
        chk("R9 write ack p1", k1, 1);
        chk("R9 write rdata zero", r0, 0);
        cyc(0, 0, 3, 21'h50000, 0, 1, 0, 3, 21'h60000, 0, 0, 0);
        chk("R10 no ack without grant", k0, 0);
        cyc(1, 0, 3, 21'h50000, 0, 1, 0, 3, 21'h60000, 0, 0, 0);
        chk("R4 bank of 0x50000", r0, 128'(VA));
        chk("R4 bank of 0x60000", r1, 128'(VB));
        chk("R9 read ack p0", k0, 1);
        p0(1, 3, 21'h4C000, 128'(VC));
        p0(0, 3, 21'h4C000, 0);
        chk("R1 lowest populated word", r0, 128'(VC));
        chk("R1 lowest populated no err", e0, 0);
    endtask

    // R3: narrow reads and writes on byte lanes.
    task automatic t_narrow;
        p0(1, 3, 21'h50010, 128'h1122_3344_5566_7788);
        p0(1, 0, 21'h50011, 128'hAB);
        p0(0, 3, 21'h50010, 0);
        chk("R3 byte write merges", r0, 128'h1122_3344_5566_AB88);
        p0(0, 1, 21'h50012, 0);
        chk("R3 half read", r0, 128'h5566);
        p0(0, 2, 21'h50014, 0);
        chk("R3 word read", r0, 128'h1122_3344);
        p0(0, 0, 21'h50011, 0);
        chk("R3 byte read", r0, 128'hAB);
    endtask

    // R5 R6: odd/even words in parallel and 16-byte accesses.
    task automatic t_interleave;
        cyc(1, 1, 3, 21'h80000, 128'(VC), 1, 1, 3, 21'h80008, 128'(VD), 0, 0);
        chk("R6 adjacent upper words g1", g1, 1);
        p0(0, 4, 21'h80000, 0);
        chk("R5 quad read", r0, {VD, VC});
        chk("R5 quad no err", e0, 0);
        p0(1, 4, 21'h80020, {VB, VA});
        cyc(1, 0, 3, 21'h80020, 0, 1, 0, 3, 21'h80028, 0, 0, 0);
        chk("R5 quad write low half", r0, 128'(VA));
        chk("R5 quad write high half", r1, 128'(VB));
        chk("R6 split read g1", g1, 1);
    endtask

    // R7: bank conflicts and priority.
    task automatic t_conflict;
        p0(1, 3, 21'h80010, 128'(VG));
        cyc(1, 0, 3, 21'h80000, 0, 1, 0, 3, 21'h80010, 0, 0, 0);
        chk("R7 port0 wins g0", g0, 1);
        chk("R7 port1 yields g1", g1, 0);
        chk("R7 port1 no ack", k1, 0);
        chk("R7 port0 data", r0, 128'(VC));
        cyc(0, 0, 0, 0, 0, 1, 0, 3, 21'h80010, 0, 0, 0);
        chk("R7 port1 retry granted", g1, 1);
        chk("R7 port1 retry data", r1, 128'(VG));
        cyc(1, 0, 4, 21'h80000, 0, 1, 0, 3, 21'h80008, 0, 0, 0);
        chk("R7 quad blocks odd bank", g1, 0);
        p0(1, 3, 21'h50008, 128'(VH));
        cyc(1, 0, 3, 21'h50000, 0, 0, 0, 0, 0, 0, 1, 21'h50008);
        chk("R7 fetch yields", gf, 0);
        chk("R7 fetch no ack", kf, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 21'h50008);
        chk("R8 fetch data", rf, VH);
        cyc(1, 0, 3, 21'h50000, 0, 0, 0, 0, 0, 0, 1, 21'h60000);
        chk("R6 fetch other bank granted", gf, 1);
        chk("R6 fetch other bank data", rf, VB);
        cyc(1, 1, 3, 21'h50000, 128'(VA), 1, 0, 3, 21'h50002, 0, 0, 0);
        chk("R7 faulty port1 not blocked", g1, 1);
        chk("R2 port1 unaligned err", e1, 1);
    endtask

    // R8: fetch restrictions.
    task automatic t_fetch;
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 21'h80000);
        chk("R8 upper fetch granted", gf, 1);
        chk("R8 upper fetch err", ef, 1);
        chk("R9 upper fetch data zero", rf, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 21'h50004);
        chk("R2 unaligned fetch err", ef, 1);
    endtask

    // R1 R2 R3: refused accesses leave memory alone.
    task automatic t_errors;
        p0(0, 3, 21'h4BFF8, 0);
        chk("R1 below window err", e0, 1);
        chk("R9 err read data zero", r0, 0);
        p0(1, 3, 21'hE8000, 128'(VD));
        chk("R1 above window err", e0, 1);
        p0(1, 3, 21'hE7FF8, 128'(VD));
        p0(0, 3, 21'hE7FF8, 0);
        chk("R1 top word no err", e0, 0);
        chk("R1 top word data", r0, 128'(VD));
        p0(1, 3, 21'h50004, 128'hFFFF_FFFF_FFFF_FFFF);
        chk("R2 unaligned write err", e0, 1);
        p0(0, 3, 21'h50000, 0);
        chk("R2 memory unchanged", r0, 128'(VA));
        p0(1, 4, 21'h50000, '1);
        chk("R3 quad in lower region err", e0, 1);
        p0(0, 3, 21'h50000, 0);
        chk("R3 lower quad left memory", r0, 128'(VA));
        p0(0, 5, 21'h50000, 0);
        chk("R3 size code 5 err", e0, 1);
        p0(0, 4, 21'h80008, 0);
        chk("R2 unaligned quad err", e0, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lower_banks();
        t_narrow();
        t_interleave();
        t_conflict();
        t_fetch();
        t_errors();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule